// File: doc/BRIEF.md
# Subcarrier Lock Stream Receiver

This block sits beside a colour subcarrier synthesizer and takes in a serial control word sent once per video line by an external video decoder. From each word it recovers a 22-bit frequency increment, a flag that marks the line phase as normal or inverted, and a request to clear the synthesizer's phase accumulator. The subcarrier can then follow small changes in line length from the source.

The serial line idles high. A word begins at a high-to-low transition and carries 67 bit slots, each two clock cycles long. Each bit is taken on the second clock of its slot. While a word is being received, further edges on the line are ignored. After the last slot, the block presents the increment, the sequence flag and the clear request together with a one-cycle load strobe. It also presents the increment widened to a 32-bit synthesizer word, with the increment in the upper 22 bits and ten zero bits below it. An enable input gates the whole function.

Top module: `sc_lock_rx`

## Requirements
- R1: While reset is asserted and after it is released, `sc_load` and `dds_clear` are 0, and `sc_inc`, `sc_word` and `seq_invert` are all zero.
- R2: A word starts only at a clock edge where `lock_sdi` is sampled low, the line was sampled high at the previous edge, and `lock_en` is high. If the line is low when reset is released, nothing starts until the line has been seen high.
- R3: Slot n (0..66) is sampled at the edge 2n+2 edges after the start edge. `sc_load` is high for exactly one cycle, beginning at the edge 134 edges after the start edge.
- R4: The increment is carried in slots 14..35, and slot 14 is the most significant bit of `sc_inc`.
- R5: `seq_invert` takes the value of slot 40 (1 = inverted line) when `sc_load` is high.
- R6: `dds_clear` is a one-cycle pulse that coincides with `sc_load`, and only when slot 46 of that word is 1.
- R7: Slots 0..13, 36..39, 41..45 and 47..66 have no effect on any output.
- R8: Falling edges inside a word are ignored, so each word produces exactly one load. A new start is accepted at the first edge after the load strobe.
- R9: `sc_word` equals `sc_inc` in bits 31..10, with bits 9..0 zero.
- R10: While `lock_en` is low, no word starts. Lowering it during a word abandons that word: there is no load and the outputs hold.
- R11: `sc_inc`, `sc_word` and `seq_invert` change only in a cycle in which `sc_load` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_en | input | 1 | Enables line-locked subcarrier reception |
| lock_sdi | input | 1 | Serial lock stream from the decoder, idles high |
| sc_inc | output | 22 | Latest frequency increment |
| sc_word | output | 32 | Increment widened to the synthesizer word |
| sc_load | output | 1 | One-cycle strobe: new increment, flag and clear request |
| seq_invert | output | 1 | Sequence flag, 1 marks an inverted line |
| dds_clear | output | 1 | One-cycle request to clear the synthesizer phase |

## Verification
The start edge is registered, so every result is timed from the edge that first sees the line low. Slot n is due two edges per slot after that edge. The load strobe and the new output values appear in the cycle after edge 134, so they are visible 135 clock edges after the start value was driven. A behavioural model counts cycles from its own start detection and compares every output at each falling clock edge, so any result that arrives one cycle early or late is reported. Directed checks also measure the start-to-load distance and count loads per word.

// File: rtl/sc_lock_pkg.sv
package sc_lock_pkg;
  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_BUSY = 1'b1
  } rx_state_e;
endpackage

// File: rtl/sc_lock_edge.sv
module sc_lock_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic fall
);
  logic line_q, line_d;

  always_comb begin
    line_d = line_in;
  end

  // Reset value 0: a line held low at reset release gives no edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= line_d;
  end

  assign fall = line_q & ~line_in;
endmodule

// File: rtl/sc_lock_timer.sv
module sc_lock_timer
  import sc_lock_pkg::*;
#(
  parameter int FRAME_BITS = 67,
  parameter int SLOT_CLKS  = 2,
  localparam int IDX_W     = $clog2(FRAME_BITS),
  localparam int PH_W      = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_en,
  input  logic             start,
  output logic             busy,
  output logic             sample_en,
  output logic             last_slot,
  output logic [IDX_W-1:0] slot_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [PH_W-1:0]  LAST_PH  = PH_W'(SLOT_CLKS - 1);

  rx_state_e        state_q, state_d;
  logic [PH_W-1:0]  phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             slot_end;

  assign slot_end = (phase_q == LAST_PH);

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    idx_d   = idx_q;
    case (state_q)
      RX_IDLE: begin
        if (lock_en && start) begin
          state_d = RX_BUSY;
          phase_d = '0;
          idx_d   = '0;
        end
      end
      RX_BUSY: begin
        if (!lock_en) begin
          state_d = RX_IDLE;
        end else if (slot_end) begin
          phase_d = '0;
          if (idx_q == LAST_IDX) state_d = RX_IDLE;
          else                   idx_d   = idx_q + IDX_W'(1);
        end else begin
          phase_d = phase_q + PH_W'(1);
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      phase_q <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      idx_q   <= idx_d;
    end
  end

  assign busy      = (state_q == RX_BUSY);
  assign sample_en = busy && lock_en && slot_end;
  assign last_slot = sample_en && (idx_q == LAST_IDX);
  assign slot_idx  = idx_q;

  assert_disable_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_en |=> (state_q == RX_IDLE));

  assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx_q <= LAST_IDX));
endmodule

// File: rtl/sc_lock_fields.sv
module sc_lock_fields #(
  parameter int FRAME_BITS = 67,
  parameter int INC_W      = 22,
  parameter int INC_POS    = 14,
  parameter int SEQ_POS    = 40,
  parameter int CLR_POS    = 46,
  localparam int IDX_W     = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic             last_slot,
  input  logic [IDX_W-1:0] slot_idx,
  input  logic             bit_in,
  output logic [INC_W-1:0] inc,
  output logic             seq,
  output logic             clr,
  output logic             load
);
  logic [INC_W-1:0] inc_sh_q, inc_sh_d;
  logic             seq_sh_q, seq_sh_d;
  logic             clr_sh_q, clr_sh_d;
  logic [INC_W-1:0] inc_q, inc_d;
  logic             seq_q, seq_d, clr_q, clr_d, load_q, load_d;

  // Most significant increment bit travels first.
  for (genvar i = 0; i < INC_W; i++) begin : g_inc_bit
    localparam int SLOT = INC_POS + INC_W - 1 - i;
    assign inc_sh_d[i] = (sample_en && slot_idx == IDX_W'(SLOT)) ? bit_in : inc_sh_q[i];
  end

  always_comb begin
    seq_sh_d = (sample_en && slot_idx == IDX_W'(SEQ_POS)) ? bit_in : seq_sh_q;
    clr_sh_d = (sample_en && slot_idx == IDX_W'(CLR_POS)) ? bit_in : clr_sh_q;
    load_d   = last_slot;
    clr_d    = last_slot && clr_sh_d;
    inc_d    = last_slot ? inc_sh_d : inc_q;
    seq_d    = last_slot ? seq_sh_d : seq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_sh_q <= '0;
      seq_sh_q <= 1'b0;
      clr_sh_q <= 1'b0;
      inc_q    <= '0;
      seq_q    <= 1'b0;
      clr_q    <= 1'b0;
      load_q   <= 1'b0;
    end else begin
      inc_sh_q <= inc_sh_d;
      seq_sh_q <= seq_sh_d;
      clr_sh_q <= clr_sh_d;
      inc_q    <= inc_d;
      seq_q    <= seq_d;
      clr_q    <= clr_d;
      load_q   <= load_d;
    end
  end

  assign inc  = inc_q;
  assign seq  = seq_q;
  assign clr  = clr_q;
  assign load = load_q;

  assert_load_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |=> !load_q);

  assert_clear_with_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |-> load_q);

  assert_hold_between_loads_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !load_q |-> ($stable(inc_q) && $stable(seq_q)));
endmodule

// File: rtl/sc_lock_rx.sv
module sc_lock_rx #(
  parameter int FRAME_BITS = 67,
  parameter int SLOT_CLKS  = 2,
  parameter int INC_W      = 22,
  parameter int INC_POS    = 14,
  parameter int SEQ_POS    = 40,
  parameter int CLR_POS    = 46,
  parameter int LOW_BITS   = 10,
  localparam int IDX_W     = $clog2(FRAME_BITS),
  localparam int WORD_W    = INC_W + LOW_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_en,
  input  logic              lock_sdi,
  output logic [INC_W-1:0]  sc_inc,
  output logic [WORD_W-1:0] sc_word,
  output logic              sc_load,
  output logic              seq_invert,
  output logic              dds_clear
);
  logic             fall, busy, sample_en, last_slot;
  logic [IDX_W-1:0] slot_idx;

  sc_lock_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_in (lock_sdi),
    .fall    (fall)
  );

  sc_lock_timer #(
    .FRAME_BITS (FRAME_BITS),
    .SLOT_CLKS  (SLOT_CLKS)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_en   (lock_en),
    .start     (fall),
    .busy      (busy),
    .sample_en (sample_en),
    .last_slot (last_slot),
    .slot_idx  (slot_idx)
  );

  sc_lock_fields #(
    .FRAME_BITS (FRAME_BITS),
    .INC_W      (INC_W),
    .INC_POS    (INC_POS),
    .SEQ_POS    (SEQ_POS),
    .CLR_POS    (CLR_POS)
  ) u_fields (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (sample_en),
    .last_slot (last_slot),
    .slot_idx  (slot_idx),
    .bit_in    (lock_sdi),
    .inc       (sc_inc),
    .seq       (seq_invert),
    .clr       (dds_clear),
    .load      (sc_load)
  );

  assign sc_word = {sc_inc, {LOW_BITS{1'b0}}};

  assert_load_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sc_load |-> $past(busy));

  assert_word_tracks_inc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sc_load |-> $stable(sc_word));
endmodule

// File: tb/sim_sc_lock_rx.sv
module sim_sc_lock_rx;
  logic        clk, rst_n, lock_en, lock_sdi;
  logic [21:0] sc_inc;
  logic [31:0] sc_word;
  logic        sc_load, seq_invert, dds_clear;

  int errors = 0, checks = 0, cyc = 0;
  int load_cnt = 0, clr_cnt = 0, last_load_cyc = 0, start_cyc = 0;
  bit done = 0;

  sc_lock_rx u0 (
    .clk(clk), .rst_n(rst_n), .lock_en(lock_en), .lock_sdi(lock_sdi),
    .sc_inc(sc_inc), .sc_word(sc_word), .sc_load(sc_load),
    .seq_invert(seq_invert), .dds_clear(dds_clear)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  // Behavioural reference model
  logic        m_prev, m_active;
  int          m_t;
  logic [66:0] m_bits;
  logic [21:0] e_inc;
  logic        e_seq, e_load, e_clr;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_prev = 0; m_active = 0; m_t = 0; m_bits = '0;
      e_inc = '0; e_seq = 0; e_load = 0; e_clr = 0;
    end else begin
      e_load = 0; e_clr = 0;
      if (m_active) begin
        if (!lock_en) m_active = 0;
        else begin
          m_t++;
          if (m_t % 2 == 0) m_bits[m_t/2 - 1] = lock_sdi;
          if (m_t == 134) begin
            for (int j = 0; j < 22; j++) e_inc[21-j] = m_bits[14+j];
            e_seq = m_bits[40];
            e_clr = m_bits[46];
            e_load = 1;
            m_active = 0;
          end
        end
      end else if (lock_en && m_prev && !lock_sdi) begin
        m_active = 1; m_t = 0;
      end
      m_prev = lock_sdi;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n !== 1'bx && cyc > 0 && !done) begin
      chk("R3 load", {31'd0, sc_load}, {31'd0, e_load});
      chk("R4 inc", {10'd0, sc_inc}, {10'd0, e_inc});
      chk("R5 seq", {31'd0, seq_invert}, {31'd0, e_seq});
      chk("R6 clear", {31'd0, dds_clear}, {31'd0, e_clr});
      chk("R9 word", sc_word, {e_inc, 10'd0});
      if (sc_load === 1'b1) begin load_cnt++; last_load_cyc = cyc; end
      if (dds_clear === 1'b1) clr_cnt++;
    end
  end

  function automatic logic [66:0] mk(input logic [21:0] inc, input logic seq,
                                     input logic clr, input int fill);
    logic [66:0] v;
    for (int n = 0; n < 67; n++) v[n] = (fill == 1) ? 1'b1 : (fill == 2) ? n[0] : 1'b0;
    for (int j = 0; j < 22; j++) v[14+j] = inc[21-j];
    v[40] = seq;
    v[46] = clr;
    return v;
  endfunction

  task automatic send(input logic [66:0] v, input int lead, input int nslots);
    repeat (lead) begin @(negedge clk); lock_sdi = 1; end
    @(negedge clk); lock_sdi = 0; start_cyc = cyc;
    for (int n = 0; n < nslots; n++) begin
      @(negedge clk); lock_sdi = v[n];
      @(negedge clk);
    end
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base;
    rst_n = 0; lock_en = 1; lock_sdi = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset load", {31'd0, sc_load}, 32'd0);
    chk("R1 reset inc", {10'd0, sc_inc}, 32'd0);
    rst_n = 1;
    repeat (20) @(negedge clk);
    chk("R1 post-reset word", sc_word, 32'd0);
    chk("R2 no start from low line", load_cnt, 0);

    // Frame 1: zero fill
    send(mk(22'h3C1F0A, 1, 0, 0), 3, 67);
    repeat (3) @(negedge clk);
    chk("R3 start-to-load distance", last_load_cyc - start_cyc, 135);
    chk("R4 increment", {10'd0, sc_inc}, {10'd0, 22'h3C1F0A});
    chk("R5 sequence flag", {31'd0, seq_invert}, 32'd1);
    chk("R9 word", sc_word, {22'h3C1F0A, 10'd0});

    // Frame 2: all reserved slots set, clear request
    send(mk(22'h3C1F0A, 0, 1, 1), 2, 67);
    // Frame 3 back to back, many internal edges
    base = load_cnt;
    send(mk(22'h000001, 1, 0, 2), 0, 67);
    repeat (3) @(negedge clk);
    chk("R8 one load per word, back-to-back accepted", load_cnt - base, 2);
    chk("R6 clear pulse count", clr_cnt, 1);
    chk("R7 reserved slots ignored", {10'd0, sc_inc}, 32'd1);

    repeat (40) @(negedge clk);
    chk("R11 hold", {10'd0, sc_inc}, 32'd1);

    // Disabled
    base = load_cnt;
    lock_en = 0;
    send(mk(22'h155555, 0, 1, 0), 2, 67);
    repeat (5) @(negedge clk);
    chk("R10 disabled no load", load_cnt - base, 0);
    chk("R10 disabled inc held", {10'd0, sc_inc}, 32'd1);

    // Abort mid-word
    lock_en = 1;
    send(mk(22'h2ABCDE, 0, 0, 0), 3, 30);
    @(negedge clk); lock_en = 0;
    @(negedge clk); lock_en = 1;
    repeat (150) @(negedge clk);
    chk("R10 aborted word", load_cnt - base, 0);

    send(mk(22'h2ABCDE, 0, 0, 1), 3, 67);
    repeat (3) @(negedge clk);
    chk("R4 after abort", {10'd0, sc_inc}, {10'd0, 22'h2ABCDE});
    chk("R2 restart after abort", load_cnt - base, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule